// File: doc/BRIEF.md
# Scanline Timing Generator with Status Flags

This block is the timing core of a picture processor. It counts dots along each scanline and scanlines down each frame. A line has 341 dots. A frame has 240 visible lines, then one post-render line, twenty vertical-blank lines and one pre-render line, for 262 lines in all. From the two counters it decodes a visible-area level and two one-cycle strobes: one marks the start of vertical blank and one marks the pre-render line.

The block also holds the three status flags that the CPU reads: vertical blank, sprite-zero hit and sprite overflow. The rendering pipeline raises single-cycle set requests for the two sprite flags. The CPU raises a single-cycle status-read strobe. The NMI output is a level that is high while the vertical-blank flag is set and the NMI-enable control input is 1.

There is no data stream in or out of this block, so every pin is a plain control or status signal with no handshake and no back-pressure.

Top module: `scan_timing_gen`

## Requirements
- R1: The dot counter runs from 0 to 340, advancing by one every clock. After 340 it returns to 0 and the line counter advances by one.
- R2: The line counter runs from 0 to 261 and then returns to 0. The `visible` output is 1 exactly while the line is 0 to 239.
- R3: `vblank_start` is high for the single cycle in which the counters read line 241, dot 1. The vertical-blank flag (status bit 7) reads 1 from the next cycle on.
- R4: `nmi` is 1 exactly when status bit 7 is 1 and `nmi_en` is 1. Changing `nmi_en` affects `nmi` in the same cycle.
- R5: `status` holds vertical blank in bit 7, sprite-zero hit in bit 6 and sprite overflow in bit 5. Bits 4 to 0 are always 0. A `status_rd` pulse clears bit 7 from the next cycle on and leaves bits 6 and 5 unchanged. If the flag is being set in the same cycle, the set takes priority over the clear.
- R6: A `hit_req` pulse sets bit 6 in the next cycle only when all three of these hold: the line is 0 to 239, `render_en` is 1, and `hit_x` is not 255. In every other case it is ignored. Once set, the bit stays set for the rest of the frame, so at most one hit is recorded per frame.
- R7: An `ovf_req` pulse on lines 0 to 239 with `render_en` at 1 sets bit 5 in the next cycle. The bit then stays set, whatever later lines report, until it is cleared as described in R8.
- R8: `prerender` is high for the single cycle at line 261, dot 1. From the next cycle on, bits 7, 6 and 5 all read 0. This clear takes priority over any set request in that same cycle.
- R9: While `rst_n` is 0, the dot and line counters read 0, `status` reads 0 and `nmi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_en | input | 1 | NMI enable control bit |
| render_en | input | 1 | Rendering enabled |
| hit_req | input | 1 | Sprite-zero hit request from the pipeline |
| hit_x | input | 8 | Horizontal position of the hit request |
| ovf_req | input | 1 | Sprite overflow request from the pipeline |
| status_rd | input | 1 | CPU status-read strobe |
| dot | output | 9 | Current dot, 0 to 340 |
| line | output | 9 | Current scanline, 0 to 261 |
| visible | output | 1 | High on lines 0 to 239 |
| vblank_start | output | 1 | One-cycle strobe at line 241, dot 1 |
| prerender | output | 1 | One-cycle strobe at line 261, dot 1 |
| status | output | 8 | Status flags in bits 7, 6 and 5 |
| nmi | output | 1 | NMI request level |

## Verification
The bench runs slightly more than one full frame and compares the outputs with expected values at chosen line and dot positions. The patterns are:
- Counter wraps at dot 340 and at line 261. These separate an off-by-one in the counter limits from a correct one.
- Sprite-zero hit requests in four cases: at position 255, with rendering disabled, on the pre-render line, and at position 254. Only the last one may set the flag, so the cases separate the position check, the enable check and the line check.
- A status read during vertical blank and another during visible lines. These show that only the vertical-blank flag is cleared by a read.
- Toggling the enable input during vertical blank. This shows that NMI follows the enable input in the same cycle rather than being latched.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Status flag group held by the flag unit
  typedef struct packed {
    logic vbl;
    logic hit;
    logic ovf;
  } scan_flags_t;

  localparam int STATUS_W   = 8;
  localparam int HIT_X_W    = 8;
  localparam int HIT_X_LAST = 255;
endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int DOTS   = 341,
  parameter int LINES  = 262,
  parameter int DOT_W  = $clog2(DOTS),
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line
);
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic end_of_line;
  assign end_of_line = (dot == DOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot <= '0;
    end else if (end_of_line) begin
      dot <= '0;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line <= '0;
    end else if (end_of_line) begin
      if (line == LINE_LAST) line <= '0;
      else                   line <= line + 1'b1;
    end
  end
endmodule

// File: rtl/scan_decode.sv
module scan_decode #(
  parameter int DOT_W      = 9,
  parameter int LINE_W     = 9,
  parameter int VIS_LINES  = 240,
  parameter int VBL_LINE   = 241,
  parameter int PRE_LINE   = 261,
  parameter int EVENT_DOT  = 1
) (
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output logic              visible,
  output logic              vblank_start,
  output logic              prerender
);
  logic at_event_dot;

  always_comb begin
    at_event_dot = (dot == DOT_W'(EVENT_DOT));
    visible      = (line < LINE_W'(VIS_LINES));
    vblank_start = at_event_dot && (line == LINE_W'(VBL_LINE));
    prerender    = at_event_dot && (line == LINE_W'(PRE_LINE));
  end
endmodule

// File: rtl/scan_flags.sv
module scan_flags
  import scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               visible,
  input  logic               vblank_start,
  input  logic               prerender,
  input  logic               render_en,
  input  logic               hit_req,
  input  logic [HIT_X_W-1:0] hit_x,
  input  logic               ovf_req,
  input  logic               status_rd,
  output scan_flags_t        flags
);
  logic hit_ok;
  logic ovf_ok;

  always_comb begin
    hit_ok = hit_req && visible && render_en && (hit_x != HIT_X_W'(HIT_X_LAST));
    ovf_ok = ovf_req && visible && render_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (prerender) begin
      flags <= '0;
    end else begin
      if (vblank_start)   flags.vbl <= 1'b1;
      else if (status_rd) flags.vbl <= 1'b0;
      if (hit_ok)         flags.hit <= 1'b1;
      if (ovf_ok)         flags.ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_pkg::*;
#(
  parameter int DOTS       = 341,
  parameter int VIS_LINES  = 240,
  parameter int POST_LINES = 1,
  parameter int VBL_LINES  = 20,
  parameter int PRE_LINES  = 1
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic                                               nmi_en,
  input  logic                                               render_en,
  input  logic                                               hit_req,
  input  logic [HIT_X_W-1:0]                                 hit_x,
  input  logic                                               ovf_req,
  input  logic                                               status_rd,
  output logic [$clog2(DOTS)-1:0]                            dot,
  output logic [$clog2(VIS_LINES+POST_LINES+VBL_LINES+PRE_LINES)-1:0] line,
  output logic                                               visible,
  output logic                                               vblank_start,
  output logic                                               prerender,
  output logic [STATUS_W-1:0]                                status,
  output logic                                               nmi
);
  localparam int LINES    = VIS_LINES + POST_LINES + VBL_LINES + PRE_LINES;
  localparam int DOT_W    = $clog2(DOTS);
  localparam int LINE_W   = $clog2(LINES);
  localparam int VBL_LINE = VIS_LINES + POST_LINES;
  localparam int PRE_LINE = LINES - PRE_LINES;

  scan_flags_t flags;

  scan_counter #(
    .DOTS(DOTS), .LINES(LINES), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line)
  );

  scan_decode #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES),
    .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .EVENT_DOT(1)
  ) u_decode (
    .dot(dot), .line(line), .visible(visible),
    .vblank_start(vblank_start), .prerender(prerender)
  );

  scan_flags u_flags (
    .clk(clk), .rst_n(rst_n), .visible(visible),
    .vblank_start(vblank_start), .prerender(prerender),
    .render_en(render_en), .hit_req(hit_req), .hit_x(hit_x),
    .ovf_req(ovf_req), .status_rd(status_rd), .flags(flags)
  );

  assign status = {flags.vbl, flags.hit, flags.ovf, {(STATUS_W-3){1'b0}}};
  assign nmi    = flags.vbl && nmi_en;
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk #(
  parameter int DOTS   = 341,
  parameter int LINES  = 262,
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_en,
  input logic              hit_req,
  input logic [7:0]        hit_x,
  input logic              status_rd,
  input logic [DOT_W-1:0]  dot,
  input logic [LINE_W-1:0] line,
  input logic              vblank_start,
  input logic              prerender,
  input logic [7:0]        status,
  input logic              nmi
);
  // R1
  dot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot != DOT_W'(DOTS-1)) |=> (dot == $past(dot) + 1'b1));
  // R1
  dot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == DOT_W'(DOTS-1)) |=> (dot == '0));
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == DOT_W'(DOTS-1) && line == LINE_W'(LINES-1)) |=> (line == '0));
  // R3
  vbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> status[7]);
  // R4
  nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi == (status[7] && nmi_en));
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !vblank_start) |=> !status[7]);
  // R5
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:0] == 5'b0);
  // R6
  hit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_req && hit_x == 8'd255 && !status[6]) |=> !status[6]);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !prerender) |=> status[5]);
  // R8
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prerender |=> (status[7:5] == 3'b000));
endmodule

bind scan_timing_gen scan_timing_chk #(
  .DOTS(DOTS), .LINES(LINES), .DOT_W(DOT_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_en(nmi_en), .hit_req(hit_req),
  .hit_x(hit_x), .status_rd(status_rd), .dot(dot), .line(line),
  .vblank_start(vblank_start), .prerender(prerender),
  .status(status), .nmi(nmi)
);

// File: tb/test_scan_timing_gen.sv
module test_scan_timing_gen;
  localparam int CLK_P = 10;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_en = 1'b1;
  logic       render_en = 1'b1;
  logic       hit_req = 1'b0;
  logic [7:0] hit_x = 8'd0;
  logic       ovf_req = 1'b0;
  logic       status_rd = 1'b0;
  logic [8:0] dot;
  logic [8:0] line;
  logic       visible, vblank_start, prerender, nmi;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit timeout = 1'b0;

  typedef struct {
    int ln; int dt; logic [7:0] st; logic nm; logic vis; logic vbs; logic pre; string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scan_timing_gen i_scan_timing_gen (
    .clk(clk), .rst_n(rst_n), .nmi_en(nmi_en), .render_en(render_en),
    .hit_req(hit_req), .hit_x(hit_x), .ovf_req(ovf_req), .status_rd(status_rd),
    .dot(dot), .line(line), .visible(visible), .vblank_start(vblank_start),
    .prerender(prerender), .status(status), .nmi(nmi)
  );

  task automatic expect_at(input int ln, input int dt, input logic [7:0] st,
                           input logic nm, input logic vis, input logic vbs,
                           input logic pre, input string tag);
    exp_t e;
    e.ln = ln; e.dt = dt; e.st = st; e.nm = nm; e.vis = vis;
    e.vbs = vbs; e.pre = pre; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && q.size() > 0 && int'(line) == q[0].ln && int'(dot) == q[0].dt) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (status !== e.st || nmi !== e.nm || visible !== e.vis ||
            vblank_start !== e.vbs || prerender !== e.pre) begin
          fails++;
          $display("FAIL %s at line %0d dot %0d: st=%h nmi=%b vis=%b vbs=%b pre=%b expected st=%h nmi=%b vis=%b vbs=%b pre=%b",
                   e.tag, e.ln, e.dt, status, nmi, visible, vblank_start, prerender,
                   e.st, e.nm, e.vis, e.vbs, e.pre);
        end
      end
    end
  end

  task automatic wait_pos(input int ln, input int dt);
    do begin
      @(negedge clk);
      if (cyc > LIMIT) timeout = 1'b1;
    end while (!(int'(line) == ln && int'(dot) == dt) && !timeout);
  endtask

  task automatic pulse_hit(input int ln, input int dt, input logic [7:0] x, input logic ren);
    wait_pos(ln, dt);
    hit_req = 1'b1; hit_x = x; render_en = ren;
    @(negedge clk);
    hit_req = 1'b0; render_en = 1'b1;
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (dot !== 9'd0 || line !== 9'd0 || status !== 8'h00 || nmi !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: dot=%0d line=%0d st=%h nmi=%b expected 0 0 00 0",
               dot, line, status, nmi);
    end

    expect_at(0, 340, 8'h00, 0, 1, 0, 0, "R1 last dot");
    expect_at(1, 0, 8'h00, 0, 1, 0, 0, "R1 dot wrap");
    expect_at(10, 101, 8'h00, 0, 1, 0, 0, "R6 hit x255 ignored");
    expect_at(10, 201, 8'h00, 0, 1, 0, 0, "R6 hit render off ignored");
    expect_at(20, 51, 8'h20, 0, 1, 0, 0, "R7 overflow set");
    expect_at(30, 41, 8'h60, 0, 1, 0, 0, "R6 hit accepted");
    expect_at(30, 101, 8'h60, 0, 1, 0, 0, "R5 read keeps sprite flags");
    expect_at(100, 0, 8'h60, 0, 1, 0, 0, "R7 overflow sticky");
    expect_at(239, 340, 8'h60, 0, 1, 0, 0, "R2 last visible");
    expect_at(240, 0, 8'h60, 0, 0, 0, 0, "R2 post-render");
    expect_at(241, 0, 8'h60, 0, 0, 0, 0, "R3 before vblank");
    expect_at(241, 1, 8'h60, 0, 0, 1, 0, "R3 vblank strobe");
    expect_at(241, 2, 8'hE0, 1, 0, 0, 0, "R3 vblank flag");
    expect_at(250, 2, 8'hE0, 1, 0, 0, 0, "R4 nmi high");
    expect_at(250, 3, 8'hE0, 0, 0, 0, 0, "R4 nmi disabled");
    expect_at(250, 4, 8'hE0, 1, 0, 0, 0, "R4 nmi re-enabled");
    expect_at(255, 11, 8'h60, 0, 0, 0, 0, "R5 read clears vblank");
    expect_at(261, 0, 8'h60, 0, 0, 0, 0, "R8 before pre-render");
    expect_at(261, 1, 8'h60, 0, 0, 0, 1, "R8 pre-render strobe");
    expect_at(261, 2, 8'h00, 0, 0, 0, 0, "R8 flags cleared");
    expect_at(261, 101, 8'h00, 0, 0, 0, 0, "R6 hit off visible ignored");
    expect_at(0, 0, 8'h00, 0, 1, 0, 0, "R2 frame wrap");
    expect_at(5, 8, 8'h40, 0, 1, 0, 0, "R6 hit x254 accepted");

    @(negedge clk);
    rst_n = 1'b1;

    pulse_hit(10, 100, 8'd255, 1'b1);
    pulse_hit(10, 200, 8'd50, 1'b0);
    wait_pos(20, 50);
    ovf_req = 1'b1;
    @(negedge clk);
    ovf_req = 1'b0;
    pulse_hit(30, 40, 8'd40, 1'b1);
    wait_pos(30, 100);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    wait_pos(250, 2);
    nmi_en = 1'b0;
    wait_pos(250, 3);
    nmi_en = 1'b1;
    wait_pos(255, 10);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    pulse_hit(261, 100, 8'd5, 1'b1);
    pulse_hit(5, 7, 8'd254, 1'b1);

    while (q.size() > 0 && !timeout) begin
      @(negedge clk);
      if (cyc > LIMIT) timeout = 1'b1;
    end
    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL watchdog: %0d expectations left, expected 0", q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule